// File: doc/BRIEF.md
# Variable-Latency Bus Slave Front End

This block sits between a 32-bit synchronous peripheral bus and a piece of user logic. It decodes its own address window, registers the bus request and hands the access to the user logic as a one-cycle request pulse. The user logic may answer in the same cycle or many cycles later, with one of three replies: done, busy or fail. The front end turns that reply into the bus response. Done gives a one-cycle acknowledge. Busy gives a retry that is held until the master drops select. Fail gives an error acknowledge together with the acknowledge. While the user logic is working, the front end raises timeout suppress so that the bus arbiter does not time the transfer out. If the master withdraws select before any response, the front end drops the access and returns to idle.

The user side is byte wide. Write data is taken from the least significant byte lane, and read data is returned on that lane with every other lane zero. The two lowest address bits are ignored, so every access is treated as word aligned. The word offset inside the window is passed to the user logic.

The controller has five states:
- `ST_IDLE` waits for a registered chip select.
- `ST_ISSUE` is the request cycle.
- `ST_WAIT` waits for a reply.
- `ST_ACK` is the acknowledge cycle.
- `ST_RETRY` holds the retry.

Its transitions are:
- decode: IDLE to ISSUE.
- reply: ISSUE or WAIT to ACK on done or fail, or to RETRY on busy.
- stall: ISSUE to WAIT with no reply.
- abort: ISSUE or WAIT to IDLE when select is low.
- release: ACK to IDLE always, and RETRY to IDLE when select is low.

Top module: `bslv_top`

## Requirements
- R1: The block responds only when select is high and the upper MATCH bits of the address equal those of BASE_ADDR. MATCH is the count of leading bit positions, from the MSB, in which BASE_ADDR and HIGH_ADDR agree. For the default window 0xFFFF8000 to 0xFFFF80FF this is 24 bits. Any other address produces no request and no response.
- R2: Each decoded transfer produces exactly one one-cycle `usr_req`, two cycles after select is first seen. The request carries:
  - `usr_addr`, equal to address bits [7:2];
  - `usr_be`, equal to the byte enables;
  - `usr_wdata`, equal to write data bits [7:0];
  - `usr_rnw`, equal to the direction flag (1 read, 0 write).
- R3: `slv_ack` is high for exactly one cycle, the cycle after the reply cycle. For a read, `slv_rdata[7:0]` holds the returned byte and bits [31:8] are zero. For a write, `slv_rdata` is zero.
- R4: If the master keeps select high and starts a new transfer in the cycle after an acknowledge, each transfer gets exactly one acknowledge.
- R5: A busy reply raises `slv_retry` in the next cycle. It stays high until select goes low and is never high together with `slv_ack`.
- R6: A fail reply raises `slv_err` and `slv_ack` together in one cycle, with `slv_rdata` zero.
- R7: `slv_tsup` is high from the request cycle until the cycle before the acknowledge, and low in the acknowledge cycle. It therefore rises well inside 16 cycles of select.
- R8: If select falls before any response, no acknowledge or retry follows, the late reply is ignored, and `slv_tsup` is low from the second cycle with select low.
- R9: While select is low, `slv_rdata`, `slv_ack`, `slv_retry` and `slv_err` are all zero.
- R10: During and right after reset, all responses and `usr_req` are zero.
- R11: After a retry, a new transfer that starts after one cycle of select low is decoded and completed normally. Address bits [1:0] have no effect on the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 32 | Byte address, valid while select is high |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rnw | input | 1 | 1 read, 0 write |
| bus_sel | input | 1 | Transfer in progress |
| slv_rdata | output | 32 | Read data, zero unless acknowledging a read |
| slv_ack | output | 1 | Transfer acknowledge |
| slv_retry | output | 1 | Retry request to master |
| slv_err | output | 1 | Error acknowledge, qualified by slv_ack |
| slv_tsup | output | 1 | Timeout suppress |
| usr_req | output | 1 | One-cycle access request |
| usr_rnw | output | 1 | Access direction |
| usr_addr | output | 6 | Word offset in window |
| usr_be | output | 4 | Byte enables |
| usr_wdata | output | 8 | Write byte |
| usr_rdata | input | 8 | Read byte, valid with usr_done |
| usr_done | input | 1 | Access complete |
| usr_busy | input | 1 | Cannot serve now, retry |
| usr_fail | input | 1 | Access failed |

## Verification
The hardest situation to reach from the ports is a master abort that lands while the user logic is still working. The reply then arrives after the controller has already gone idle, and it must not turn into a stray acknowledge. The bench sets a long user-side latency, drops select partway through the wait, and lets the modelled user logic answer several cycles later. It then watches for any response and checks that suppress goes low in time. The back-to-back case is also staged: select is held high through an acknowledge and straight into the next transfer, which exposes any double acknowledge caused by the stale registered select.

// File: rtl/bslv_pkg.sv
package bslv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_ACK,
        ST_RETRY
    } bslv_state_t;

    // Number of leading bit positions (from the MSB) in which two
    // addresses of width w agree.
    function automatic int match_len(input logic [63:0] a,
                                     input logic [63:0] b,
                                     input int w);
        int n;
        n = w;
        for (int i = 0; i < w; i++) begin
            if (n == w && a[w-1-i] != b[w-1-i]) n = i;
        end
        return n;
    endfunction

endpackage

// File: rtl/bslv_decode.sv
module bslv_decode #(
    parameter int                MATCH_W = 24,
    parameter logic [MATCH_W-1:0] BASE_TOP = '1
) (
    input  logic [MATCH_W-1:0] addr_top,
    input  logic               sel,
    output logic               hit
);

    assign hit = sel && (addr_top == BASE_TOP);

endmodule

// File: rtl/bslv_capture.sv
module bslv_capture #(
    parameter int LOC_W  = 6,
    parameter int BE_W   = 4,
    parameter int USR_DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              clr,
    input  logic              sel,
    input  logic [LOC_W-1:0]  loc_in,
    input  logic [BE_W-1:0]   be_in,
    input  logic [USR_DW-1:0] wd_in,
    input  logic              rnw_in,
    output logic              cs_q,
    output logic [LOC_W-1:0]  loc_q,
    output logic [BE_W-1:0]   be_q,
    output logic [USR_DW-1:0] wd_q,
    output logic              rnw_q
);

    // Chip select is cleared by the slave's own acknowledge, so the
    // still-selected bus cycle that carries the ack is not re-decoded.
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= 1'b0;
        end else begin
            cs_q <= hit && !clr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_q <= '0;
            be_q  <= '0;
            wd_q  <= '0;
            rnw_q <= 1'b0;
        end else if (sel) begin
            loc_q <= loc_in;
            be_q  <= be_in;
            wd_q  <= wd_in;
            rnw_q <= rnw_in;
        end
    end

endmodule

// File: rtl/bslv_ctrl.sv
module bslv_ctrl
    import bslv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_q,
    input  logic hit,
    input  logic bus_sel,
    input  logic rep_done,
    input  logic rep_busy,
    input  logic rep_fail,
    output logic issue_o,
    output logic ack_o,
    output logic err_o,
    output logic retry_o,
    output logic tsup_o,
    output logic in_ack,
    output logic take_rd
);

    bslv_state_t state, state_nx;
    logic        err_q, err_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            err_q <= 1'b0;
        end else begin
            state <= state_nx;
            err_q <= err_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        err_nx   = err_q;
        unique case (state)
            ST_IDLE: begin
                if (cs_q) state_nx = ST_ISSUE;
            end
            ST_ISSUE, ST_WAIT: begin
                if (!bus_sel) begin
                    state_nx = ST_IDLE;           // abort
                end else if (rep_fail) begin
                    state_nx = ST_ACK;
                    err_nx   = 1'b1;
                end else if (rep_done) begin
                    state_nx = ST_ACK;
                    err_nx   = 1'b0;
                end else if (rep_busy) begin
                    state_nx = ST_RETRY;
                end else begin
                    state_nx = ST_WAIT;
                end
            end
            ST_ACK: begin
                state_nx = ST_IDLE;
            end
            ST_RETRY: begin
                if (!bus_sel) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        issue_o = 1'b0;
        ack_o   = 1'b0;
        err_o   = 1'b0;
        retry_o = 1'b0;
        tsup_o  = 1'b0;
        in_ack  = 1'b0;
        take_rd = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ISSUE: begin
                issue_o = bus_sel;
                tsup_o  = bus_sel;
                take_rd = bus_sel && rep_done && !rep_fail;
            end
            ST_WAIT: begin
                tsup_o  = 1'b1;
                take_rd = bus_sel && rep_done && !rep_fail;
            end
            ST_ACK: begin
                in_ack = 1'b1;
                ack_o  = bus_sel;
                err_o  = bus_sel && err_q;
            end
            ST_RETRY: begin
                retry_o = bus_sel;
            end
            default: ;
        endcase
    end

    // cycles selected with no sign of life, for the timeout window check
    logic [4:0] quiet_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_cnt <= '0;
        end else if (hit && !tsup_o && !ack_o && !retry_o) begin
            if (quiet_cnt != 5'd31) quiet_cnt <= quiet_cnt + 5'd1;
        end else begin
            quiet_cnt <= '0;
        end
    end

    a_r3_ack_single: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);
    a_r5_no_ack_with_retry: assert property (@(posedge clk) disable iff (rst)
        !(ack_o && retry_o));
    a_r6_err_needs_ack: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ack_o);
    a_r2_req_single: assert property (@(posedge clk) disable iff (rst)
        issue_o |=> !issue_o);
    a_r8_tsup_tail: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel && $past(!bus_sel)) |-> !tsup_o);
    a_r7_tsup_window: assert property (@(posedge clk) disable iff (rst)
        quiet_cnt < 5'd16);

endmodule

// File: rtl/bslv_top.sv
module bslv_top
    import bslv_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              DATA_W    = 32,
    parameter int              USR_DW    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_8000,
    parameter logic [ADDR_W-1:0] HIGH_ADDR = 32'hFFFF_80FF,
    localparam int             MATCH_W   = match_len(64'(BASE_ADDR), 64'(HIGH_ADDR), ADDR_W),
    localparam int             LOC_W     = ADDR_W - MATCH_W - 2,
    localparam int             BE_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rnw,
    input  logic              bus_sel,
    output logic [DATA_W-1:0] slv_rdata,
    output logic              slv_ack,
    output logic              slv_retry,
    output logic              slv_err,
    output logic              slv_tsup,
    output logic              usr_req,
    output logic              usr_rnw,
    output logic [LOC_W-1:0]  usr_addr,
    output logic [BE_W-1:0]   usr_be,
    output logic [USR_DW-1:0] usr_wdata,
    input  logic [USR_DW-1:0] usr_rdata,
    input  logic              usr_done,
    input  logic              usr_busy,
    input  logic              usr_fail
);

    logic hit, cs_q, rnw_q, in_ack, take_rd, ack_i, err_i;
    logic [USR_DW-1:0] rd_q;

    logic unused_bits;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:USR_DW]};

    bslv_decode #(
        .MATCH_W (MATCH_W),
        .BASE_TOP(BASE_ADDR[ADDR_W-1 -: MATCH_W])
    ) u_dec (
        .addr_top(bus_addr[ADDR_W-1 -: MATCH_W]),
        .sel     (bus_sel),
        .hit     (hit)
    );

    bslv_capture #(
        .LOC_W (LOC_W),
        .BE_W  (BE_W),
        .USR_DW(USR_DW)
    ) u_cap (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .clr   (in_ack),
        .sel   (bus_sel),
        .loc_in(bus_addr[LOC_W+1:2]),
        .be_in (bus_be),
        .wd_in (bus_wdata[USR_DW-1:0]),
        .rnw_in(bus_rnw),
        .cs_q  (cs_q),
        .loc_q (usr_addr),
        .be_q  (usr_be),
        .wd_q  (usr_wdata),
        .rnw_q (rnw_q)
    );

    bslv_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cs_q    (cs_q),
        .hit     (hit),
        .bus_sel (bus_sel),
        .rep_done(usr_done),
        .rep_busy(usr_busy),
        .rep_fail(usr_fail),
        .issue_o (usr_req),
        .ack_o   (ack_i),
        .err_o   (err_i),
        .retry_o (slv_retry),
        .tsup_o  (slv_tsup),
        .in_ack  (in_ack),
        .take_rd (take_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (take_rd) begin
            rd_q <= usr_rdata;
        end
    end

    assign usr_rnw   = rnw_q;
    assign slv_ack   = ack_i;
    assign slv_err   = err_i;
    assign slv_rdata = (ack_i && rnw_q && !err_i) ? DATA_W'(rd_q) : '0;

    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> (slv_rdata == '0 && !slv_ack && !slv_retry && !slv_err));
    a_r3_rdata_only_on_ack: assert property (@(posedge clk) disable iff (rst)
        !slv_ack |-> slv_rdata == '0);

endmodule

// File: tb/bslv_top_test.sv
module bslv_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rnw = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] slv_rdata;
    logic        slv_ack, slv_retry, slv_err, slv_tsup;
    logic        usr_req, usr_rnw;
    logic [5:0]  usr_addr;
    logic [3:0]  usr_be;
    logic [7:0]  usr_wdata;
    logic [7:0]  usr_rdata = '0;
    logic        usr_done = 1'b0, usr_busy = 1'b0, usr_fail = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bslv_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rnw(bus_rnw), .bus_sel(bus_sel),
        .slv_rdata(slv_rdata), .slv_ack(slv_ack), .slv_retry(slv_retry),
        .slv_err(slv_err), .slv_tsup(slv_tsup), .usr_req(usr_req),
        .usr_rnw(usr_rnw), .usr_addr(usr_addr), .usr_be(usr_be),
        .usr_wdata(usr_wdata), .usr_rdata(usr_rdata), .usr_done(usr_done),
        .usr_busy(usr_busy), .usr_fail(usr_fail)
    );

    int total = 0;
    int failed = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // kind: 0 ack, 1 ack+err, 2 retry
    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] rdata;
    } exp_t;
    exp_t exp_q[$];

    // expected request fields
    logic [5:0] e_addr;
    logic [3:0] e_be;
    logic [7:0] e_wd;
    logic       e_rnw;
    int         req_seen = 0;
    int         ack_seen = 0;

    // back-end model configuration: 0 done, 1 busy, 2 fail
    int         cfg_delay = 0;
    int         cfg_resp  = 0;
    logic [7:0] cfg_byte  = '0;

    // back-end model
    initial begin
        bit pend = 0;
        int cnt = 0;
        forever begin
            @(posedge clk);
            #2;
            usr_done = 1'b0; usr_busy = 1'b0; usr_fail = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    pend = 0;
                    usr_done = (cfg_resp == 0);
                    usr_busy = (cfg_resp == 1);
                    usr_fail = (cfg_resp == 2);
                    usr_rdata = cfg_byte;
                end else begin
                    cnt--;
                end
            end
            if (usr_req) begin
                if (cfg_delay == 0) begin
                    usr_done = (cfg_resp == 0);
                    usr_busy = (cfg_resp == 1);
                    usr_fail = (cfg_resp == 2);
                    usr_rdata = cfg_byte;
                end else begin
                    pend = 1;
                    cnt = cfg_delay - 1;
                end
            end
        end
    end

    // monitor / scoreboard
    initial begin
        logic prev_retry = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (usr_req) begin
                    req_seen++;
                    chk(usr_addr == e_addr, "R2 usr_addr", 32'(usr_addr), 32'(e_addr));
                    chk(usr_be == e_be, "R2 usr_be", 32'(usr_be), 32'(e_be));
                    chk(usr_wdata == e_wd, "R2 usr_wdata", 32'(usr_wdata), 32'(e_wd));
                    chk(usr_rnw == e_rnw, "R2 usr_rnw", 32'(usr_rnw), 32'(e_rnw));
                end
                if (slv_ack || (slv_retry && !prev_retry)) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R8 unexpected response", {slv_ack, slv_retry}, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        if (slv_ack) ack_seen++;
                        chk(e.kind == {slv_retry, slv_err}, "R5/R6 response kind",
                            32'({slv_retry, slv_err}), 32'(e.kind));
                        chk(slv_rdata == e.rdata, "R3 read data", slv_rdata, e.rdata);
                    end
                end
                prev_retry = slv_retry;
            end
        end
    end

    // one transfer; called and returns at posedge+1
    task automatic xfer(input logic [31:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input logic rnw, input int dly,
                        input int resp, input logic [7:0] rb, input bit keep);
        exp_t e;
        int n;
        cfg_delay = dly; cfg_resp = resp; cfg_byte = rb;
        e_addr = a[7:2]; e_be = be; e_wd = wd[7:0]; e_rnw = rnw;
        e.kind  = (resp == 1) ? 2'd2 : (resp == 2) ? 2'd1 : 2'd0;
        e.rdata = (resp == 0 && rnw) ? {24'h0, rb} : 32'h0;
        exp_q.push_back(e);
        bus_addr = a; bus_be = be; bus_wdata = wd; bus_rnw = rnw; bus_sel = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (slv_ack || slv_retry) break;
            if (n >= 3) chk(slv_tsup == 1'b1, "R7 tsup during wait", 32'(slv_tsup), 1);
            if (n > 60) break;
        end
        chk(n == dly + 4, "R3 response latency", n, dly + 4);
        if (slv_ack) chk(slv_tsup == 1'b0, "R7 tsup low at ack", 32'(slv_tsup), 0);
        if (slv_retry) begin
            for (int i = 0; i < 2; i++) begin
                @(posedge clk); #1;
                @(negedge clk);
                chk(slv_retry && !slv_ack, "R5 retry held", {slv_retry, slv_ack}, 2);
            end
            @(posedge clk); #1;
            bus_sel = 1'b0;
            @(negedge clk);
            chk(!slv_retry, "R5 retry drops with select", 32'(slv_retry), 0);
            @(posedge clk); #1;
        end else begin
            @(posedge clk); #1;
            if (!keep) bus_sel = 1'b0;
        end
    endtask

    initial begin
        int r0, a0;
        repeat (3) @(negedge clk);
        chk(!slv_ack && !slv_retry && !slv_err && !slv_tsup && !usr_req && slv_rdata == 0,
            "R10 reset outputs", {slv_ack, slv_retry, slv_err, slv_tsup, usr_req}, 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk(!slv_ack && !slv_tsup && slv_rdata == 0, "R10 after reset",
            {slv_ack, slv_tsup}, 0);
        @(posedge clk); #1;

        // R3 reads and writes at various latencies
        xfer(32'hFFFF_8010, 4'h1, 32'h0, 1'b1, 0, 0, 8'hA5, 0);
        xfer(32'hFFFF_80FC, 4'hF, 32'h1234_56C3, 1'b0, 3, 0, 8'h00, 0);
        // R7 long wait, suppress held
        xfer(32'hFFFF_8004, 4'h1, 32'h0, 1'b1, 14, 0, 8'h3C, 0);
        // R6 error
        xfer(32'hFFFF_8008, 4'h1, 32'h0, 1'b1, 2, 2, 8'hFF, 0);
        // R5 retry, then R11 new transfer after select low; R11 low bits ignored
        xfer(32'hFFFF_8020, 4'h1, 32'h77, 1'b0, 1, 1, 8'h00, 0);
        xfer(32'hFFFF_8013, 4'h2, 32'h0, 1'b1, 1, 0, 8'h5A, 0);

        // R4 back-to-back with select held
        a0 = ack_seen; r0 = req_seen;
        xfer(32'hFFFF_8030, 4'h1, 32'h11, 1'b0, 0, 0, 8'h00, 1);
        xfer(32'hFFFF_8034, 4'h1, 32'h0, 1'b1, 1, 0, 8'h99, 0);
        repeat (4) @(negedge clk);
        chk(ack_seen - a0 == 2, "R4 one ack each", ack_seen - a0, 2);
        chk(req_seen - r0 == 2, "R4 one request each", req_seen - r0, 2);
        @(posedge clk); #1;

        // R1/R9 non-matching address
        r0 = req_seen;
        bus_addr = 32'hFFFF_9000; bus_rnw = 1'b1; bus_sel = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!slv_ack && !slv_retry && !slv_tsup && slv_rdata == 0,
                "R1 no response off window", {slv_ack, slv_retry, slv_tsup}, 0);
        end
        chk(req_seen == r0, "R1 no request off window", req_seen - r0, 0);
        @(posedge clk); #1; bus_sel = 1'b0;

        // R8 abort during a long back-end wait
        r0 = req_seen;
        cfg_delay = 10; cfg_resp = 0; cfg_byte = 8'hEE;
        e_addr = 6'h02; e_be = 4'h1; e_wd = 8'h00; e_rnw = 1'b1;
        bus_addr = 32'hFFFF_8008; bus_be = 4'h1; bus_wdata = '0; bus_rnw = 1'b1;
        bus_sel = 1'b1;
        repeat (5) begin @(posedge clk); #1; end
        bus_sel = 1'b0;
        for (int i = 1; i <= 14; i++) begin
            @(negedge clk);
            chk(!slv_ack && !slv_retry && slv_rdata == 0, "R8 no response after abort",
                {slv_ack, slv_retry}, 0);
            if (i >= 2) chk(!slv_tsup, "R8 tsup released", 32'(slv_tsup), 0);
        end
        chk(req_seen - r0 == 1, "R8 single request", req_seen - r0, 1);
        chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);

        // R9 idle outputs zero
        @(negedge clk);
        chk(!slv_ack && !slv_retry && !slv_err && slv_rdata == 0, "R9 idle quiet",
            {slv_ack, slv_retry, slv_err}, 0);

        finished = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule